// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control and status register bank of a multi-channel DMA controller with up to 32 channels. It keeps a global control word and four per-channel bitmaps: request enable, error-interrupt enable, pending transfer interrupts and latched errors. Done and error event pulses from the transfer engine set the pending bits. The block drives one transfer interrupt and one error interrupt line.

Software changes one channel's bit without a read-modify-write. It writes the channel number as a single byte to a command register that sets or clears that bit. The pending bitmaps can also be cleared in bulk by writing ones to them. The register bus carries byte, halfword and word accesses. A mode input makes the bank appear big-endian: word data is byte-reversed and sub-word addresses are remapped before decoding.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: The control word at offset 0x00 stores only bits 1-7, 16 and 17. Every other bit reads zero, whatever was written.
- R3: Offset 0x0C is the read/write request-enable bitmap and offset 0x14 is the read/write error-interrupt-enable bitmap. Bit n belongs to channel n.
- R4: A byte write of value v to offset 0x1B sets request-enable bit v[4:0], and to offset 0x1A clears it. No other bit changes. Bits 7:5 of v are ignored.
- R5: A byte write of v to offset 0x19 sets error-interrupt-enable bit v[4:0], and to offset 0x18 clears it.
- R6: A pulse on done_evt[n] sets bit n of the pending-interrupt bitmap at 0x24. A byte write of n to 0x1F clears that bit. Writing ones to 0x24 clears the matching bits.
- R7: A pulse on err_evt[n] sets bit n of the error bitmap at 0x2C. A byte write of n to 0x1E clears that bit. Writing ones to 0x2C clears the matching bits.
- R8: If an event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: irq_xfer is high whenever any pending-interrupt bit is set. irq_err is high whenever an error bit is set and its error-interrupt-enable bit is also set. Both follow the register state one clock edge after the causing event or write.
- R10: With big_endian high, a word's data is byte-reversed, a byte address is XORed with 3, and a halfword address is XORed with 2 and its two data bytes swapped.
- R11: acc_size selects the access width: 0 for byte, 1 for halfword, 2 for word. Sub-word data sits in the low bits of acc_wdata and acc_rdata. A sub-word write changes only the addressed bytes.
- R12: Unused offsets and the command registers (0x18-0x1F) read zero. Writes to unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | AW | Byte offset |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Write data, right-aligned for sub-word |
| acc_rdata | output | 32 | Read data, combinational, right-aligned |
| big_endian | input | 1 | Big-endian presentation of the bank |
| done_evt | input | NCH | Per-channel transfer-done pulses |
| err_evt | input | NCH | Per-channel error pulses |
| ctrl_o | output | 32 | Global control word |
| req_en_o | output | NCH | Request-enable bitmap |
| irq_xfer | output | 1 | Transfer interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Read data is combinational. The bench drives a read on the falling edge and samples it one nanosecond later, in the same cycle. A write or an event pulse presented during one cycle changes the state and the interrupt lines at the next rising edge. The bench therefore holds stimulus for exactly one cycle and looks at the outputs only after the following falling edge. The same-cycle race is produced by driving the event and the clear command in the same low phase.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 32,
  parameter int AW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic [31:0]     acc_wdata,
  output logic [31:0]     acc_rdata,
  input  logic            big_endian,
  input  logic [NCH-1:0]  done_evt,
  input  logic [NCH-1:0]  err_evt,
  output logic [31:0]     ctrl_o,
  output logic [NCH-1:0]  req_en_o,
  output logic            irq_xfer,
  output logic            irq_err
);
  localparam logic [31:0] CTRL_MASK = 32'h0003_00FE;
  localparam int WI = AW - 2;

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [NCH-1:0] chan_bit(input logic [7:0] b);
    if (int'(b[4:0]) < NCH) return {{(NCH-1){1'b0}}, 1'b1} << b[4:0];
    return '0;
  endfunction

  logic [31:0]    ctrl_q;
  logic [NCH-1:0] req_q, ie_q, intr_q, err_q;

  logic [1:0]    swz;
  logic [AW-1:0] ea;
  logic [WI-1:0] widx;
  logic [31:0]   nat, lane, wmask;
  logic [3:0]    bmask;
  logic          we;

  assign swz  = !big_endian ? 2'd0 : (acc_size == 2'd0) ? 2'd3 : (acc_size == 2'd1) ? 2'd2 : 2'd0;
  assign ea   = acc_addr ^ {{(AW-2){1'b0}}, swz};
  assign widx = ea[AW-1:2];
  assign we   = acc_en && acc_wr;

  always_comb begin
    if (acc_size[1])        nat = big_endian ? bswap(acc_wdata) : acc_wdata;
    else if (acc_size[0])   nat = {16'b0, big_endian ? {acc_wdata[7:0], acc_wdata[15:8]} : acc_wdata[15:0]};
    else                    nat = {24'b0, acc_wdata[7:0]};
    if (acc_size[1])        begin lane = nat;                bmask = 4'hF; end
    else if (acc_size[0])   begin lane = {2{nat[15:0]}};     bmask = ea[1] ? 4'hC : 4'h3; end
    else                    begin lane = {4{nat[7:0]}};      bmask = 4'b0001 << ea[1:0]; end
    wmask = {{8{bmask[3]}}, {8{bmask[2]}}, {8{bmask[1]}}, {8{bmask[0]}}};
  end

  logic hit0, hit3, hit5, hit6, hit7, hit9, hit11;
  assign hit0  = we && widx == WI'(0);
  assign hit3  = we && widx == WI'(3);
  assign hit5  = we && widx == WI'(5);
  assign hit6  = we && widx == WI'(6);
  assign hit7  = we && widx == WI'(7);
  assign hit9  = we && widx == WI'(9);
  assign hit11 = we && widx == WI'(11);

  logic [NCH-1:0] clr_ie, set_ie, clr_rq, set_rq, clr_er, clr_in, w1c_in, w1c_er;
  assign clr_ie = (hit6 && bmask[0]) ? chan_bit(lane[7:0])   : '0;
  assign set_ie = (hit6 && bmask[1]) ? chan_bit(lane[15:8])  : '0;
  assign clr_rq = (hit6 && bmask[2]) ? chan_bit(lane[23:16]) : '0;
  assign set_rq = (hit6 && bmask[3]) ? chan_bit(lane[31:24]) : '0;
  assign clr_er = (hit7 && bmask[2]) ? chan_bit(lane[23:16]) : '0;
  assign clr_in = (hit7 && bmask[3]) ? chan_bit(lane[31:24]) : '0;

  logic [31:0] req32, ie32, intr32, err32, req_mg, ie_mg, ones;
  assign req32  = 32'(req_q);
  assign ie32   = 32'(ie_q);
  assign intr32 = 32'(intr_q);
  assign err32  = 32'(err_q);
  assign req_mg = (req32 & ~wmask) | (lane & wmask);
  assign ie_mg  = (ie32 & ~wmask) | (lane & wmask);
  assign ones   = lane & wmask;
  assign w1c_in = hit9  ? ones[NCH-1:0] : '0;
  assign w1c_er = hit11 ? ones[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      req_q  <= '0;
      ie_q   <= '0;
      intr_q <= '0;
      err_q  <= '0;
    end else begin
      if (hit0) ctrl_q <= ((ctrl_q & ~wmask) | (lane & wmask)) & CTRL_MASK;
      req_q  <= hit3 ? req_mg[NCH-1:0] : ((req_q & ~clr_rq) | set_rq);
      ie_q   <= hit5 ? ie_mg[NCH-1:0]  : ((ie_q & ~clr_ie) | set_ie);
      intr_q <= (intr_q & ~w1c_in & ~clr_in) | done_evt;
      err_q  <= (err_q & ~w1c_er & ~clr_er) | err_evt;
    end
  end

  logic [31:0] rword, rsh;
  always_comb begin
    case (widx)
      WI'(0):  rword = ctrl_q;
      WI'(3):  rword = req32;
      WI'(5):  rword = ie32;
      WI'(9):  rword = intr32;
      WI'(11): rword = err32;
      default: rword = '0;
    endcase
    if (acc_size[1]) begin
      rsh = big_endian ? bswap(rword) : rword;
    end else if (acc_size[0]) begin
      rsh = rword >> {ea[1], 4'b0};
      rsh = {16'b0, big_endian ? {rsh[7:0], rsh[15:8]} : rsh[15:0]};
    end else begin
      rsh = rword >> {ea[1:0], 3'b0};
      rsh = {24'b0, rsh[7:0]};
    end
  end

  assign acc_rdata = (acc_en && !acc_wr) ? rsh : '0;
  assign ctrl_o    = ctrl_q;
  assign req_en_o  = req_q;
  assign irq_xfer  = |intr_q;
  assign irq_err   = |(err_q & ie_q);

  p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((intr_q & $past(done_evt)) == $past(done_evt)));
  p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((err_q & $past(err_evt)) == $past(err_evt)));
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_xfer) |-> $past(done_evt != '0));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> $stable(req_en_o));
  p_pend_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> (($past(intr_q) & ~intr_q) == '0));
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int NCH = 32;
  localparam int AW  = 6;

  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0, big_endian = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_size = 2'd2;
  logic [31:0] acc_wdata = '0, acc_rdata, ctrl_o;
  logic [NCH-1:0] done_evt = '0, err_evt = '0, req_en_o;
  logic irq_xfer, irq_err;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_chan_regs #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .big_endian(big_endian), .done_evt(done_evt),
    .err_evt(err_evt), .ctrl_o(ctrl_o), .req_en_o(req_en_o),
    .irq_xfer(irq_xfer), .irq_err(irq_err));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_size = s;
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic rchk(input string req, input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, s, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    rchk("R1 ctrl", 6'h00, 2, 0);
    rchk("R1 req", 6'h0C, 2, 0);
    rchk("R1 ie", 6'h14, 2, 0);
    rchk("R1 intr", 6'h24, 2, 0);
    rchk("R1 err", 6'h2C, 2, 0);
    chk("R1 irqs", {30'b0, irq_xfer, irq_err}, 0);
  endtask

  task automatic t_ctrl();
    wr(6'h00, 2, 32'hFFFF_FFFF);
    rchk("R2 mask", 6'h00, 2, 32'h0003_00FE);
    wr(6'h00, 0, 32'h0000_0000);
    rchk("R11 byte write", 6'h00, 2, 32'h0003_0000);
    wr(6'h02, 1, 32'h0000_0001);
    rchk("R11 half write", 6'h00, 2, 32'h0001_0000);
    rchk("R11 half read", 6'h02, 1, 32'h0000_0001);
    chk("R2 ctrl_o", ctrl_o, 32'h0001_0000);
    wr(6'h00, 2, 0);
  endtask

  task automatic t_bitmaps();
    wr(6'h0C, 2, 32'hA5A5_0F0F);
    wr(6'h14, 2, 32'h1234_5678);
    rchk("R3 req", 6'h0C, 2, 32'hA5A5_0F0F);
    rchk("R3 ie", 6'h14, 2, 32'h1234_5678);
    rchk("R11 byte read", 6'h0D, 0, 32'h0000_000F);
    wr(6'h0C, 2, 0);
    wr(6'h14, 2, 0);
  endtask

  task automatic t_cmd();
    wr(6'h1B, 0, 5);
    chk("R4 set", req_en_o, 32'h0000_0020);
    wr(6'h1B, 0, 32'hE3);
    chk("R4 low bits", req_en_o, 32'h0000_0028);
    wr(6'h1A, 0, 5);
    rchk("R4 clear", 6'h0C, 2, 32'h0000_0008);
    wr(6'h19, 0, 31);
    rchk("R5 set", 6'h14, 2, 32'h8000_0000);
    wr(6'h18, 0, 31);
    rchk("R5 clear", 6'h14, 2, 0);
    rchk("R12 cmd reads zero", 6'h18, 2, 0);
    wr(6'h1A, 0, 3);
  endtask

  task automatic t_intr();
    @(negedge clk); done_evt = 32'h11;
    @(negedge clk); done_evt = '0;
    chk("R9 irq_xfer high", {31'b0, irq_xfer}, 1);
    rchk("R6 set", 6'h24, 2, 32'h11);
    wr(6'h1F, 0, 0);
    rchk("R6 cmd clear", 6'h24, 2, 32'h10);
    wr(6'h24, 2, 32'hFFFF_FFFF);
    rchk("R6 w1c", 6'h24, 2, 0);
    chk("R9 irq_xfer low", {31'b0, irq_xfer}, 0);
  endtask

  task automatic t_err();
    @(negedge clk); err_evt = 32'h4;
    @(negedge clk); err_evt = '0;
    rchk("R7 set", 6'h2C, 2, 32'h4);
    chk("R9 irq_err masked", {31'b0, irq_err}, 0);
    wr(6'h19, 0, 2);
    chk("R9 irq_err enabled", {31'b0, irq_err}, 1);
    wr(6'h1E, 0, 2);
    rchk("R7 cmd clear", 6'h2C, 2, 0);
    chk("R9 irq_err low", {31'b0, irq_err}, 0);
    @(negedge clk); err_evt = 32'h100;
    @(negedge clk); err_evt = '0;
    wr(6'h2C, 2, 32'h100);
    rchk("R7 w1c", 6'h2C, 2, 0);
    wr(6'h14, 2, 0);
  endtask

  task automatic t_race();
    @(negedge clk); done_evt = 32'h80;
    @(negedge clk); done_evt = 32'h80;
    acc_en = 1; acc_wr = 1; acc_addr = 6'h1F; acc_size = 0; acc_wdata = 7;
    @(negedge clk); done_evt = '0; acc_en = 0; acc_wr = 0;
    rchk("R8 event wins", 6'h24, 2, 32'h80);
    wr(6'h1F, 0, 7);
    rchk("R8 later clear", 6'h24, 2, 0);
  endtask

  task automatic t_unused();
    wr(6'h30, 2, 32'hFFFF_FFFF);
    rchk("R12 unused", 6'h30, 2, 0);
    rchk("R12 offset 4", 6'h04, 2, 0);
    rchk("R12 no side effect", 6'h00, 2, 0);
  endtask

  task automatic t_be();
    big_endian = 1;
    wr(6'h0C, 2, 32'h1122_3344);
    rchk("R10 word read be", 6'h0C, 2, 32'h1122_3344);
    big_endian = 0;
    rchk("R10 word swapped", 6'h0C, 2, 32'h4433_2211);
    big_endian = 1;
    rchk("R10 byte addr", 6'h0F, 0, 32'h11);
    big_endian = 0;
    wr(6'h0C, 2, 0);
    big_endian = 1;
    wr(6'h18, 0, 4);
    chk("R10 byte cmd", req_en_o, 32'h10);
    wr(6'h00, 1, 32'h0100);
    chk("R10 half write", ctrl_o, 32'h0001_0000);
    rchk("R10 half read", 6'h00, 1, 32'h0100);
    big_endian = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_bitmaps();
    t_cmd();
    t_intr();
    t_err();
    t_race();
    t_unused();
    t_be();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule